// File: doc/BRIEF.md
# Floating-Point Control Register Write Unit

This block owns a 32-bit floating-point control register and handles every write made to it. Three commands can change the register. A full load replaces the whole word. A load-and-signal replaces the word but keeps the old sticky flags, and it can trap on them. A rounding-field update changes only the low three bits. The block checks each new value before it is installed. A value that fails the checks is dropped, and the block raises a specification-exception pulse. The rounding field is decoded at all times into a compact rounding-mode code, which the arithmetic datapath uses.

For a load-and-signal, the block ANDs the flags held before the write with the new enable mask. When any bit survives, one condition is picked by a fixed priority and a data-exception pulse carries an 8-bit code. The command port uses a valid/ready handshake. `cmd_ready` is low in reset and goes high on the first clock edge after reset, then stays high, so the block never applies back-pressure. A command is taken on every rising edge where both `cmd_valid` and `cmd_ready` are high. All results appear on the cycle after the edge that accepts the command.

Top module: `fpc_write_unit`

## Requirements
- R1: After reset, `ctrl_reg` is 0, `rnd_mode` is 0, and `spec_exc` and `data_exc` are low.
- R2: An accepted full load (op 0) with a legal operand writes the operand into `ctrl_reg` unchanged. The new value is visible on the cycle after acceptance.
- R3: For op 0 and op 1, a rounding code (operand bits 2:0) of 4, 5 or 6 raises `spec_exc` for one cycle and leaves `ctrl_reg` unchanged.
- R4: For op 0 and op 1, any operand bit set under mask 0x03030088 raises `spec_exc` for one cycle and leaves `ctrl_reg` unchanged.
- R5: For op 0 and op 1, when `ext_fp_en` is low, operand bit 2 raises `spec_exc` and leaves `ctrl_reg` unchanged. When `ext_fp_en` is high, bit 2 is legal.
- R6: An accepted legal load-and-signal (op 1) writes the operand ORed with the old flag byte, which is `ctrl_reg` bits 23:16.
- R7: For a legal op 1, the trap set is the old bits 23:16 ANDed with the new operand bits 31:24. If the trap set is nonzero, `data_exc` pulses for one cycle. `data_exc_code` is then the chosen condition bits ORed with 0x03. The conditions, in priority order, are:
  - invalid, bit 7: gives 0x80.
  - divide-by-zero, bit 6: gives 0x40.
  - overflow, bit 5: gives 0x20, plus 0x08 if inexact is also in the set.
  - underflow, bit 4: gives 0x10, plus 0x08 if inexact is also in the set.
  - inexact, bit 3: gives 0x08.
  - quantum, bit 2: gives 0x04.
  A command that raises `spec_exc` never raises `data_exc`.
- R8: The rounding-field update (op 2) replaces only bits 2:0 with operand bits 2:0. An operand above 7, or a code of 4, 5 or 6, raises `spec_exc` and leaves the register unchanged.
- R9: `rnd_mode` is derived from `ctrl_reg` bits 2:0 as follows:
  - code 0 gives 0 (nearest-even).
  - code 1 gives 1 (toward zero).
  - code 2 gives 2 (toward +infinity).
  - code 3 gives 3 (toward -infinity).
  - code 7 gives 4 (round-to-odd).
- R10: Op 3, or a cycle with `cmd_valid` low, changes nothing and raises no pulse.
- R11: `cmd_ready` goes high on the first clock edge after reset and stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted when high together with valid |
| cmd_op | input | 2 | 0 full load, 1 load-and-signal, 2 rounding-field update, 3 no operation |
| cmd_data | input | 32 | Command operand |
| ext_fp_en | input | 1 | Extended floating-point feature enable |
| ctrl_reg | output | 32 | Current control register value |
| rnd_mode | output | 3 | Decoded rounding mode |
| spec_exc | output | 1 | One-cycle specification-exception pulse |
| data_exc | output | 1 | One-cycle data-exception pulse |
| data_exc_code | output | 8 | Data-exception code, valid while `data_exc` is high |

## Verification
Most of the stimulus is random, drawn from four operand shapes:
- Raw 32-bit words hit the reserved-bit check and the illegal-code check together.
- Words with the reserved bits cleared and random masks and flags drive the load-and-signal trap path.
- Small values from 0 to 15 separate the over-range check of the rounding-field update from its illegal-code check.
- Words with a fixed legal rounding code check decoding on its own.

Directed cases set one flag bit per priority level, so the priority chain can be told apart from a plain OR of the flags. Other directed cases pair inexact with overflow and with underflow to confirm the added 0x08 bit. Further cases toggle `ext_fp_en` around bit 2.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

  typedef enum logic [1:0] {
    OP_LOAD     = 2'd0,
    OP_LOAD_SIG = 2'd1,
    OP_SET_RM   = 2'd2,
    OP_NONE     = 2'd3
  } fpc_op_e;

  typedef enum logic [2:0] {
    RM_NEAR_EVEN = 3'd0,
    RM_ZERO      = 3'd1,
    RM_POS_INF   = 3'd2,
    RM_NEG_INF   = 3'd3,
    RM_ODD       = 3'd4
  } rnd_e;

  // Rounding codes 4..6 have no meaning.
  function automatic logic rm_code_legal(input logic [2:0] c);
    return !((c == 3'd4) || (c == 3'd5) || (c == 3'd6));
  endfunction

endpackage

// File: rtl/fpc_check.sv
module fpc_check
  import fpc_pkg::*;
#(
  parameter int          W        = 32,
  parameter logic [31:0] RESV     = 32'h0303_0088,
  parameter int          FLAG_LSB = 16,
  parameter int          FLAG_W   = 8,
  parameter int          RM_W     = 3,
  parameter int          EXT_BIT  = 2
) (
  input  logic [1:0]   op,
  input  logic [W-1:0] data,
  input  logic         ext_en,
  input  logic [W-1:0] old_reg,
  output logic         bad,
  output logic [W-1:0] new_val
);
  localparam logic [W-1:0] FLAG_MASK =
    {{(W-FLAG_W){1'b0}}, {FLAG_W{1'b1}}} << FLAG_LSB;
  localparam logic [W-1:0] RESV_W = RESV[W-1:0];

  logic full_bad;
  logic rm_bad;

  always_comb begin
    full_bad = !rm_code_legal(data[RM_W-1:0])
             || ((data & RESV_W) != '0)
             || (!ext_en && data[EXT_BIT]);
    rm_bad   = (data[W-1:RM_W] != '0) || !rm_code_legal(data[RM_W-1:0]);
    bad      = 1'b0;
    new_val  = old_reg;
    case (fpc_op_e'(op))
      OP_LOAD: begin
        bad     = full_bad;
        new_val = data;
      end
      OP_LOAD_SIG: begin
        bad     = full_bad;
        new_val = data | (old_reg & FLAG_MASK);
      end
      OP_SET_RM: begin
        bad     = rm_bad;
        new_val = {old_reg[W-1:RM_W], data[RM_W-1:0]};
      end
      default: begin
        bad     = 1'b0;
        new_val = old_reg;
      end
    endcase
  end
endmodule

// File: rtl/fpc_trap_sel.sv
module fpc_trap_sel #(
  parameter int         FW       = 8,
  parameter logic [7:0] CODE_LOW = 8'h03
) (
  input  logic [FW-1:0] old_flags,
  input  logic [FW-1:0] new_mask,
  output logic          hit,
  output logic [7:0]    code
);
  localparam int B_INV = 7;
  localparam int B_DVZ = 6;
  localparam int B_OVF = 5;
  localparam int B_UNF = 4;
  localparam int B_INX = 3;
  localparam int B_QNT = 2;

  logic [FW-1:0] trap;
  logic [7:0]    sel;

  always_comb begin
    trap = old_flags & new_mask;
    hit  = (trap != '0);
    sel  = 8'h00;
    if (trap[B_INV])      sel[B_INV] = 1'b1;
    else if (trap[B_DVZ]) sel[B_DVZ] = 1'b1;
    else if (trap[B_OVF]) begin
      sel[B_OVF] = 1'b1;
      sel[B_INX] = trap[B_INX];
    end
    else if (trap[B_UNF]) begin
      sel[B_UNF] = 1'b1;
      sel[B_INX] = trap[B_INX];
    end
    else if (trap[B_INX]) sel[B_INX] = 1'b1;
    else if (trap[B_QNT]) sel[B_QNT] = 1'b1;
    code = sel | CODE_LOW;
  end
endmodule

// File: rtl/fpc_rm_decode.sv
module fpc_rm_decode
  import fpc_pkg::*;
(
  input  logic [2:0] code,
  output logic [2:0] rm
);
  rnd_e m;
  always_comb begin
    case (code)
      3'd0:    m = RM_NEAR_EVEN;
      3'd1:    m = RM_ZERO;
      3'd2:    m = RM_POS_INF;
      3'd3:    m = RM_NEG_INF;
      3'd7:    m = RM_ODD;
      default: m = RM_NEAR_EVEN;
    endcase
    rm = m;
  end
endmodule

// File: rtl/fpc_write_unit.sv
module fpc_write_unit
  import fpc_pkg::*;
#(
  parameter int          W        = 32,
  parameter logic [31:0] RESV     = 32'h0303_0088,
  parameter int          FLAG_LSB = 16,
  parameter int          MASK_LSB = 24,
  parameter int          FLAG_W   = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmd_valid,
  output logic         cmd_ready,
  input  logic [1:0]   cmd_op,
  input  logic [W-1:0] cmd_data,
  input  logic         ext_fp_en,
  output logic [W-1:0] ctrl_reg,
  output logic [2:0]   rnd_mode,
  output logic         spec_exc,
  output logic         data_exc,
  output logic [7:0]   data_exc_code
);
  logic         bad;
  logic [W-1:0] new_val;
  logic         hit;
  logic [7:0]   tcode;
  logic         take;

  fpc_check #(
    .W(W), .RESV(RESV), .FLAG_LSB(FLAG_LSB), .FLAG_W(FLAG_W),
    .RM_W(3), .EXT_BIT(2)
  ) u_check (
    .op(cmd_op), .data(cmd_data), .ext_en(ext_fp_en),
    .old_reg(ctrl_reg), .bad(bad), .new_val(new_val)
  );

  fpc_trap_sel #(.FW(FLAG_W), .CODE_LOW(8'h03)) u_trap (
    .old_flags(ctrl_reg[FLAG_LSB +: FLAG_W]),
    .new_mask (cmd_data[MASK_LSB +: FLAG_W]),
    .hit(hit), .code(tcode)
  );

  fpc_rm_decode u_rm (.code(ctrl_reg[2:0]), .rm(rnd_mode));

  assign take = cmd_valid && cmd_ready && (fpc_op_e'(cmd_op) != OP_NONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_reg      <= '0;
      cmd_ready     <= 1'b0;
      spec_exc      <= 1'b0;
      data_exc      <= 1'b0;
      data_exc_code <= 8'h00;
    end else begin
      cmd_ready     <= 1'b1;
      spec_exc      <= 1'b0;
      data_exc      <= 1'b0;
      data_exc_code <= 8'h00;
      if (take) begin
        if (bad) begin
          spec_exc <= 1'b1;
        end else begin
          ctrl_reg <= new_val;
          if ((fpc_op_e'(cmd_op) == OP_LOAD_SIG) && hit) begin
            data_exc      <= 1'b1;
            data_exc_code <= tcode;
          end
        end
      end
    end
  end
endmodule

// File: rtl/fpc_write_unit_chk.sv
module fpc_write_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_ready,
  input logic [31:0] ctrl_reg,
  input logic [2:0]  rnd_mode,
  input logic        spec_exc,
  input logic        data_exc,
  input logic [7:0]  data_exc_code
);
  function automatic logic [2:0] exp_rm(input logic [2:0] c);
    return (c == 3'd7) ? 3'd4 : c;
  endfunction

  p_spec_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    spec_exc |-> (ctrl_reg == $past(ctrl_reg)));

  p_no_resv_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_reg & 32'h0303_0088) == 32'h0);

  p_flags_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    data_exc |-> ((ctrl_reg[23:16] & $past(ctrl_reg[23:16])) == $past(ctrl_reg[23:16])));

  p_code_form_r7: assert property (@(posedge clk) disable iff (!rst_n)
    data_exc |-> ((data_exc_code[1:0] == 2'b11) && (data_exc_code[7:2] != 6'd0)
                  && $onehot0({data_exc_code[7:4], data_exc_code[2]})));

  p_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(spec_exc && data_exc));

  p_legal_rm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctrl_reg[2:0] inside {3'd4, 3'd5, 3'd6}));

  p_rm_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rnd_mode == exp_rm(ctrl_reg[2:0]));

  p_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |=> cmd_ready);
endmodule

bind fpc_write_unit fpc_write_unit_chk i_chk (
  .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready), .ctrl_reg(ctrl_reg),
  .rnd_mode(rnd_mode), .spec_exc(spec_exc), .data_exc(data_exc),
  .data_exc_code(data_exc_code)
);

// File: tb/test_fpc_write_unit.sv
`timescale 1ns/1ps
module test_fpc_write_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [1:0]  cmd_op = 2'd0;
  logic [31:0] cmd_data = 32'h0;
  logic        ext_fp_en = 1'b1;
  logic [31:0] ctrl_reg;
  logic [2:0]  rnd_mode;
  logic        spec_exc;
  logic        data_exc;
  logic [7:0]  data_exc_code;

  int checks = 0;
  int errors = 0;
  logic [31:0] m_reg = 32'h0;

  always #2 clk = ~clk;

  fpc_write_unit i_fpc_write_unit (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_data(cmd_data), .ext_fp_en(ext_fp_en),
    .ctrl_reg(ctrl_reg), .rnd_mode(rnd_mode), .spec_exc(spec_exc),
    .data_exc(data_exc), .data_exc_code(data_exc_code)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] ref_rm(input logic [2:0] c);
    case (c)
      3'd7:    return 3'd4;
      3'd1:    return 3'd1;
      3'd2:    return 3'd2;
      3'd3:    return 3'd3;
      default: return 3'd0;
    endcase
  endfunction

  function automatic logic [7:0] ref_code(input logic [7:0] t);
    logic [7:0] inx;
    inx = t & 8'h08;
    casez (t)
      8'b1???????: return 8'h83;
      8'b01??????: return 8'h43;
      8'b001?????: return 8'h23 | inx;
      8'b0001????: return 8'h13 | inx;
      8'b00001???: return 8'h0B;
      default:     return 8'h07;
    endcase
  endfunction

  task automatic cmd(input string tag, input logic v, input logic [1:0] op,
                     input logic [31:0] d, input logic ext);
    logic       sp, dx;
    logic [7:0] cd;
    logic [31:0] nr;
    logic bad_rm;
    sp = 1'b0; dx = 1'b0; cd = 8'h00; nr = m_reg;
    bad_rm = (d[2:0] >= 3'd4) && (d[2:0] <= 3'd6);
    cmd_valid = v; cmd_op = op; cmd_data = d; ext_fp_en = ext;
    if (v && op != 2'd3) begin
      if (op == 2'd2) begin
        sp = (d > 32'd7) || bad_rm;
        nr = {m_reg[31:3], d[2:0]};
      end else begin
        sp = bad_rm || ((d & 32'h0303_0088) != 0) || (!ext && d[2]);
        nr = (op == 2'd1) ? (d | {8'h00, m_reg[23:16], 16'h0}) : d;
        if (op == 2'd1 && !sp && ((m_reg[23:16] & d[31:24]) != 0)) begin
          dx = 1'b1;
          cd = ref_code(m_reg[23:16] & d[31:24]);
        end
      end
      if (!sp) m_reg = nr;
    end
    @(negedge clk);
    cmd_valid = 1'b0;
    chk({tag, " reg"}, ctrl_reg, m_reg);
    chk({tag, " spec"}, {31'h0, spec_exc}, {31'h0, sp});
    chk({tag, " dexc (R7)"}, {31'h0, data_exc}, {31'h0, dx});
    if (dx) chk({tag, " code (R7)"}, {24'h0, data_exc_code}, {24'h0, cd});
    chk("R9 rnd_mode", {29'h0, rnd_mode}, {29'h0, ref_rm(m_reg[2:0])});
  endtask

  initial begin
    #(4 * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1 reg", ctrl_reg, 32'h0);
    chk("R1 rnd", {29'h0, rnd_mode}, 32'h0);
    chk("R1 pulses", {30'h0, spec_exc, data_exc}, 32'h0);
    chk("R11 ready in reset", {31'h0, cmd_ready}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 ready", {31'h0, cmd_ready}, 32'h1);

    cmd("R2", 1'b1, 2'd0, 32'hFC00_0071, 1'b1);
    cmd("R3", 1'b1, 2'd0, 32'h0000_0005, 1'b1);
    cmd("R3", 1'b1, 2'd1, 32'h0000_0006, 1'b1);
    cmd("R4", 1'b1, 2'd0, 32'h0100_0000, 1'b1);
    cmd("R4", 1'b1, 2'd0, 32'h0000_0080, 1'b1);
    cmd("R5", 1'b1, 2'd0, 32'h0000_0007, 1'b0);
    cmd("R5", 1'b1, 2'd0, 32'h0000_0007, 1'b1);
    cmd("R8", 1'b1, 2'd2, 32'h0000_0008, 1'b1);
    cmd("R8", 1'b1, 2'd2, 32'h0000_0004, 1'b1);
    cmd("R8", 1'b1, 2'd2, 32'h0000_0002, 1'b1);
    cmd("R10", 1'b1, 2'd3, 32'hFFFF_FFFF, 1'b1);
    cmd("R10", 1'b0, 2'd0, 32'h0000_0001, 1'b1);
    // R7 priority: one flag per level, then inexact paired with ovf/unf
    for (int b = 2; b < 8; b++) begin
      cmd("R6", 1'b1, 2'd0, 32'h0000_0000 | (32'h1 << (16 + b)), 1'b1);
      cmd("R7", 1'b1, 2'd1, 32'hFC00_0000, 1'b1);
    end
    cmd("R6", 1'b1, 2'd0, 32'h0028_0000, 1'b1);
    cmd("R7", 1'b1, 2'd1, 32'h2800_0001, 1'b1);
    cmd("R6", 1'b1, 2'd0, 32'h0018_0000, 1'b1);
    cmd("R7", 1'b1, 2'd1, 32'hFC00_0000, 1'b1);
    cmd("R6", 1'b1, 2'd0, 32'h00FC_0000, 1'b1);
    cmd("R7", 1'b1, 2'd1, 32'h0400_0003, 1'b1);
    cmd("R7", 1'b1, 2'd1, 32'h0400_0005, 1'b1);

    for (int i = 0; i < 600; i++) begin
      logic [31:0] d;
      logic [1:0]  op;
      logic [2:0]  rmc;
      string tg;
      op = 2'($urandom % 4);
      case ($urandom % 4)
        0: d = $urandom;
        1: d = $urandom & ~32'h0303_0088;
        2: d = $urandom % 16;
        default: begin
          case ($urandom % 5)
            0: rmc = 3'd0; 1: rmc = 3'd1; 2: rmc = 3'd2; 3: rmc = 3'd3;
            default: rmc = 3'd7;
          endcase
          d = ($urandom & ~32'h0303_008F) | {29'h0, rmc};
        end
      endcase
      case (op)
        2'd0: tg = "R2 rand";
        2'd1: tg = "R6 rand";
        2'd2: tg = "R8 rand";
        default: tg = "R10 rand";
      endcase
      cmd(tg, ($urandom % 8) != 0, op, d, ($urandom % 4) != 0);
    end
    chk("R11 ready end", {31'h0, cmd_ready}, 32'h1);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule